// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the programming port of a pixel readout chip. Several chips share one clock line, one framing line (`cfg_en`), one serial input and one serial output. A host shifts a frame into every chip at once. The frame holds three header fields and then, for writes, a data payload. Only the chip whose strapped identifier matches the header field acts on the frame. Every other chip keeps its output low, so the outputs of all chips can be wired-OR together.

The registers behind the port are:
- fourteen 8-bit bias settings, held in parallel for the analog periphery;
- two 576-bit per-pixel mask chains, one that disables pixels and one that enables charge injection.

A read shifts a copy of the register out on the serial line and leaves the stored value untouched. The register outputs change only on an accepted write, so a readback has no effect on the readout logic.

Top module: `cfg_serial_port`

## Requirements
- R1: After a synchronous reset:
  - every bias setting equals `DAC_DEFAULT` (8'h80);
  - both mask chains are all zero;
  - `cfg_sout` is 0.
- R2: A frame is sampled MSB first on each rising edge while `cfg_en` is high. Its fields are, in order:
  - chip ID (5 bits);
  - register address (5 bits);
  - command (3 bits);
  - data.

  A write (command 3'b001) to address 0..13, with the ID matching `chip_id` and exactly 8 data bits, loads that bias setting. Setting i appears on `dac_bus[8i+7:8i]` right after the decode edge.
- R3: A matching write to address 14 loads the kill chain and a write to address 15 loads the inject chain. Each carries exactly 576 data bits, and the first data bit lands in bit 575.
- R4: A frame whose ID differs from `chip_id` changes no register and never drives `cfg_sout`.
- R5: A matching read (command 3'b010) is a header-only frame of 13 bits. It puts the addressed register on `cfg_sout` MSB first, 8 bits for a bias setting and 576 bits for a chain. The first bit appears one clock after the decode edge. The stored value is unchanged.
- R6: `cfg_sout` is 0 in every cycle where it is not presenting read data, including the cycle just after the decode edge.
- R7: Command codes other than 3'b001 and 3'b010 change nothing and produce no output.
- R8: Addresses 16..31 are ignored by both writes and reads.
- R9: The bit count is checked before a frame is accepted:
  - a write with any data length other than the register's width is ignored;
  - a read frame longer than 13 bits is ignored.
- R10: A frame is decoded on the first rising edge that samples `cfg_en` low after it was high. A new frame may begin on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| chip_id | input | 5 | Strapped chip identifier |
| cfg_en | input | 1 | Frame envelope, high while bits are shifted |
| cfg_sin | input | 1 | Serial frame input |
| cfg_sout | output | 1 | Serial read data, low when idle |
| dac_bus | output | 112 | Fourteen 8-bit bias settings, setting i at bits 8i+7:8i |
| kill_mask | output | 576 | Per-pixel disable chain |
| inject_mask | output | 576 | Per-pixel injection enable chain |

## Verification
A corrupt bit counter or header register shows up at the ports one edge after decode:
- a write lands on the wrong setting, or on none at all;
- a read starts with the wrong length.

The bench compares every bias and mask output against its own model after each frame, so a stray write is seen within one cycle. A read that copies the wrong register, or shifts it in the wrong order, appears in the first differing serial bit, which is at most 576 cycles after decode. An idle output that drives a 1 would corrupt the shared bus; the bench samples `cfg_sout` during foreign, malformed and ignored frames to catch this.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int ID_W   = 5;
  localparam int ADDR_W = 5;
  localparam int CMD_W  = 3;
  localparam int HDR_W  = ID_W + ADDR_W + CMD_W;

  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b001;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'b010;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
  } hdr_t;

  // bit counter width: header + longest payload + one overflow marker
  function automatic int cnt_width(input int data_w);
    return $clog2(HDR_W + data_w + 2);
  endfunction
endpackage

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_pkg::*;
#(
  parameter int DATA_W = 576,
  parameter int CNT_W  = cnt_width(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_en,
  input  logic              sin,
  output hdr_t              hdr,
  output logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  nbits,
  output logic              decode
);
  localparam int MAX_BITS = HDR_W + DATA_W + 1;

  logic              en_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  pos;

  // bits already taken in this frame; restarts on a rising envelope
  assign pos = en_q ? cnt_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      data_q <= '0;
    end else begin
      en_q <= frame_en;
      if (frame_en) begin
        if (pos != CNT_W'(MAX_BITS)) cnt_q <= pos + 1'b1;
        if (pos < CNT_W'(HDR_W)) hdr_q  <= {hdr_q[HDR_W-2:0], sin};
        else                     data_q <= {data_q[DATA_W-2:0], sin};
      end
    end
  end

  assign hdr    = hdr_t'(hdr_q);
  assign data   = data_q;
  assign nbits  = cnt_q;
  assign decode = en_q && !frame_en;

  a_r10_frame_start: assert property (@(posedge clk) disable iff (rst)
    (frame_en && !en_q) |=> (nbits == CNT_W'(1)));

  a_r9_count_limit: assert property (@(posedge clk) disable iff (rst)
    nbits <= CNT_W'(MAX_BITS));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int          NUM_DAC     = 14,
  parameter int          DAC_W       = 8,
  parameter int          CHAIN_LEN   = 576,
  parameter logic [7:0]  DAC_DEFAULT = 8'h80,
  parameter int          CNT_W       = cnt_width(CHAIN_LEN),
  parameter int          LEN_W       = $clog2(CHAIN_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ID_W-1:0]            chip_id,
  input  logic                       decode,
  input  hdr_t                       hdr,
  input  logic [CHAIN_LEN-1:0]       data,
  input  logic [CNT_W-1:0]           nbits,
  output logic [NUM_DAC*DAC_W-1:0]   dac_flat,
  output logic [CHAIN_LEN-1:0]       kill_q,
  output logic [CHAIN_LEN-1:0]       inj_q,
  output logic                       rd_load,
  output logic [CHAIN_LEN-1:0]       rd_word,
  output logic [LEN_W-1:0]           rd_len
);
  localparam int KILL_ADDR = NUM_DAC;
  localparam int INJ_ADDR  = NUM_DAC + 1;

  logic [DAC_W-1:0] dac_q [NUM_DAC];
  logic [DAC_W-1:0] dac_sel;
  logic hit, is_dac, is_kill, is_inj, wr_ok, rd_ok;

  assign hit     = decode && (hdr.id == chip_id);
  assign is_dac  = hdr.addr < ADDR_W'(NUM_DAC);
  assign is_kill = hdr.addr == ADDR_W'(KILL_ADDR);
  assign is_inj  = hdr.addr == ADDR_W'(INJ_ADDR);

  assign wr_ok = hit && (hdr.cmd == CMD_WRITE) &&
                 ((is_dac && nbits == CNT_W'(HDR_W + DAC_W)) ||
                  ((is_kill || is_inj) && nbits == CNT_W'(HDR_W + CHAIN_LEN)));
  assign rd_ok = hit && (hdr.cmd == CMD_READ) && (nbits == CNT_W'(HDR_W)) &&
                 (is_dac || is_kill || is_inj);

  genvar g;
  generate
    for (g = 0; g < NUM_DAC; g++) begin : gen_dac
      always_ff @(posedge clk) begin
        if (rst)                                               dac_q[g] <= DAC_DEFAULT[DAC_W-1:0];
        else if (wr_ok && is_dac && hdr.addr == ADDR_W'(g))     dac_q[g] <= data[DAC_W-1:0];
      end
      assign dac_flat[g*DAC_W +: DAC_W] = dac_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_q <= '0;
      inj_q  <= '0;
    end else if (wr_ok) begin
      if (is_kill) kill_q <= data;
      if (is_inj)  inj_q  <= data;
    end
  end

  always_comb begin
    dac_sel = '0;
    for (int i = 0; i < NUM_DAC; i++)
      if (hdr.addr == ADDR_W'(i)) dac_sel = dac_q[i];
  end

  // bias values are left-aligned so the serializer always shifts from the top
  always_comb begin
    rd_word = '0;
    rd_len  = LEN_W'(DAC_W);
    if (is_kill) begin
      rd_word = kill_q;
      rd_len  = LEN_W'(CHAIN_LEN);
    end else if (is_inj) begin
      rd_word = inj_q;
      rd_len  = LEN_W'(CHAIN_LEN);
    end else begin
      rd_word[CHAIN_LEN-1 -: DAC_W] = dac_sel;
    end
  end

  assign rd_load = rd_ok;

  a_r4_foreign_id_no_write: assert property (@(posedge clk) disable iff (rst)
    (decode && hdr.id != chip_id) |=>
      ($stable(dac_flat) && $stable(kill_q) && $stable(inj_q)));

  a_r5_read_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (decode && hdr.cmd == CMD_READ) |=>
      ($stable(dac_flat) && $stable(kill_q) && $stable(inj_q)));

  a_r8_high_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (decode && hdr.addr > ADDR_W'(INJ_ADDR)) |=>
      ($stable(dac_flat) && $stable(kill_q) && $stable(inj_q)));

  a_r7_bad_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (decode && hdr.cmd != CMD_WRITE) |=>
      ($stable(dac_flat) && $stable(kill_q) && $stable(inj_q)));
endmodule

// File: rtl/cfg_rd_tx.sv
module cfg_rd_tx #(
  parameter int CHAIN_LEN = 576,
  parameter int LEN_W     = $clog2(CHAIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [CHAIN_LEN-1:0] word,
  input  logic [LEN_W-1:0]     len,
  output logic                 sout
);
  logic [CHAIN_LEN-1:0] sreg;
  logic [LEN_W-1:0]     left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      left <= '0;
      sout <= 1'b0;
    end else if (load) begin
      sreg <= word;
      left <= len;
      sout <= 1'b0;
    end else if (left != '0) begin
      sout <= sreg[CHAIN_LEN-1];
      sreg <= {sreg[CHAIN_LEN-2:0], 1'b0};
      left <= left - 1'b1;
    end else begin
      sout <= 1'b0;
    end
  end

  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    (left == '0) |=> !sout);

  a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
    left <= LEN_W'(CHAIN_LEN));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_pkg::*;
#(
  parameter int         NUM_DAC     = 14,
  parameter int         DAC_W       = 8,
  parameter int         ROWS        = 32,
  parameter int         COLS        = 18,
  parameter logic [7:0] DAC_DEFAULT = 8'h80,
  localparam int        CHAIN_LEN   = ROWS * COLS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ID_W-1:0]          chip_id,
  input  logic                     cfg_en,
  input  logic                     cfg_sin,
  output logic                     cfg_sout,
  output logic [NUM_DAC*DAC_W-1:0] dac_bus,
  output logic [CHAIN_LEN-1:0]     kill_mask,
  output logic [CHAIN_LEN-1:0]     inject_mask
);
  localparam int CNT_W = cnt_width(CHAIN_LEN);
  localparam int LEN_W = $clog2(CHAIN_LEN + 1);

  hdr_t                 hdr;
  logic [CHAIN_LEN-1:0] data;
  logic [CNT_W-1:0]     nbits;
  logic                 decode;
  logic                 rd_load;
  logic [CHAIN_LEN-1:0] rd_word;
  logic [LEN_W-1:0]     rd_len;

  cfg_frame_rx #(.DATA_W(CHAIN_LEN), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .frame_en(cfg_en), .sin(cfg_sin),
    .hdr(hdr), .data(data), .nbits(nbits), .decode(decode)
  );

  cfg_reg_bank #(
    .NUM_DAC(NUM_DAC), .DAC_W(DAC_W), .CHAIN_LEN(CHAIN_LEN),
    .DAC_DEFAULT(DAC_DEFAULT), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_bank (
    .clk(clk), .rst(rst), .chip_id(chip_id), .decode(decode), .hdr(hdr),
    .data(data), .nbits(nbits), .dac_flat(dac_bus), .kill_q(kill_mask),
    .inj_q(inject_mask), .rd_load(rd_load), .rd_word(rd_word), .rd_len(rd_len)
  );

  cfg_rd_tx #(.CHAIN_LEN(CHAIN_LEN), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .load(rd_load), .word(rd_word), .len(rd_len),
    .sout(cfg_sout)
  );
endmodule

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;
  localparam int NUM_DAC = 14;
  localparam int DAC_W   = 8;
  localparam int CHAIN   = 576;
  localparam int FW      = 600;
  localparam logic [4:0] MY_ID = 5'd9;

  logic clk = 1'b0, rst = 1'b1, cfg_en = 1'b0, cfg_sin = 1'b0;
  logic cfg_sout;
  logic [NUM_DAC*DAC_W-1:0] dac_bus;
  logic [CHAIN-1:0] kill_mask, inject_mask;

  cfg_serial_port uut (
    .clk(clk), .rst(rst), .chip_id(MY_ID), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
    .cfg_sout(cfg_sout), .dac_bus(dac_bus), .kill_mask(kill_mask),
    .inject_mask(inject_mask)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] m_dac [NUM_DAC];

  // id, addr, cmd, data, is_read, expected read byte
  localparam logic [29:0] VEC [12] = '{
    {5'd9,  5'd0,  3'b001, 8'h5A, 1'b0, 8'h00},
    {5'd9,  5'd13, 3'b001, 8'hC3, 1'b0, 8'h00},
    {5'd3,  5'd0,  3'b001, 8'hFF, 1'b0, 8'h00},
    {5'd9,  5'd0,  3'b010, 8'h00, 1'b1, 8'h5A},
    {5'd9,  5'd13, 3'b010, 8'h00, 1'b1, 8'hC3},
    {5'd9,  5'd5,  3'b011, 8'h11, 1'b0, 8'h00},
    {5'd9,  5'd5,  3'b010, 8'h00, 1'b1, 8'h80},
    {5'd9,  5'd20, 3'b001, 8'h77, 1'b0, 8'h00},
    {5'd9,  5'd7,  3'b000, 8'h22, 1'b0, 8'h00},
    {5'd3,  5'd0,  3'b010, 8'h00, 1'b1, 8'h00},
    {5'd9,  5'd5,  3'b001, 8'h01, 1'b0, 8'h00},
    {5'd9,  5'd5,  3'b010, 8'h00, 1'b1, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input logic [CHAIN-1:0] act,
                     input logic [CHAIN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NUM_DAC*DAC_W-1:0] exp_dac();
    logic [NUM_DAC*DAC_W-1:0] f;
    for (int i = 0; i < NUM_DAC; i++) f[i*DAC_W +: DAC_W] = m_dac[i];
    return f;
  endfunction

  function automatic logic [CHAIN-1:0] pattern(input int seed);
    logic [CHAIN-1:0] p;
    for (int i = 0; i < CHAIN; i++) p[i] = (((i * seed) + (i / 7)) % 5) < 2;
    return p;
  endfunction

  task automatic send(input logic [FW-1:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1'b1; cfg_sin = v[i];
    end
    @(negedge clk); cfg_en = 1'b0; cfg_sin = 1'b0;
  endtask

  task automatic collect(input int len, input string req, output logic [CHAIN-1:0] got);
    got = '0;
    @(negedge clk);
    chk(cfg_sout == 1'b0, req, CHAIN'(cfg_sout), '0);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); got[i] = cfg_sout;
    end
  endtask

  task automatic expect_silent(input int cycles, input string req);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); seen = seen | cfg_sout;
    end
    chk(seen == 1'b0, req, CHAIN'(seen), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] v;
    logic [CHAIN-1:0] got, kp, ip;
    for (int i = 0; i < NUM_DAC; i++) m_dac[i] = 8'h80;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dac_bus == exp_dac(), "R1 bias reset", CHAIN'(dac_bus), CHAIN'(exp_dac()));
    chk(kill_mask == '0 && inject_mask == '0, "R1 chains reset", kill_mask | inject_mask, '0);
    chk(cfg_sout == 1'b0, "R1 sout reset", CHAIN'(cfg_sout), '0);

    // table walk: R2 R4 R5 R7 R8 on bias settings
    for (int k = 0; k < 12; k++) begin
      logic [29:0] e;
      logic [4:0] id, ad;
      logic [2:0] cm;
      logic [7:0] dt, ex;
      e = VEC[k];
      {id, ad, cm, dt} = e[29:9];
      ex = e[7:0];
      if (e[8]) begin
        v = '0; v[12:0] = {id, ad, cm};
        send(v, 13);
        collect(8, "R6 read lead-in", got);
        chk(got[7:0] == ex, $sformatf("R5 table[%0d] read", k), got, CHAIN'(ex));
      end else begin
        v = '0; v[20:0] = {id, ad, cm, dt};
        send(v, 21);
        @(negedge clk);
        if (id == MY_ID && cm == 3'b001 && ad < 5'd14) m_dac[ad] = dt;
      end
      chk(dac_bus == exp_dac(), $sformatf("R2 R4 R7 R8 table[%0d] bias", k),
          CHAIN'(dac_bus), CHAIN'(exp_dac()));
    end

    // R3 chain writes
    kp = pattern(3);
    ip = pattern(11);
    v = '0; v[CHAIN+12:0] = {MY_ID, 5'd14, 3'b001, kp};
    send(v, CHAIN + 13);
    @(negedge clk);
    chk(kill_mask == kp, "R3 kill write", kill_mask, kp);
    chk(inject_mask == '0, "R3 inject untouched", inject_mask, '0);
    v = '0; v[CHAIN+12:0] = {MY_ID, 5'd15, 3'b001, ip};
    send(v, CHAIN + 13);
    @(negedge clk);
    chk(inject_mask == ip && kill_mask == kp, "R3 inject write", inject_mask, ip);

    // R5 chain readback, non-destructive; R6 idle after it
    v = '0; v[12:0] = {MY_ID, 5'd14, 3'b010};
    send(v, 13);
    collect(CHAIN, "R6 chain lead-in", got);
    chk(got == kp, "R5 kill readback", got, kp);
    chk(kill_mask == kp, "R5 kill kept", kill_mask, kp);
    @(negedge clk);
    chk(cfg_sout == 1'b0, "R6 after read", CHAIN'(cfg_sout), '0);

    // R4 foreign chain write
    v = '0; v[CHAIN+12:0] = {5'd3, 5'd15, 3'b001, {CHAIN{1'b1}}};
    send(v, CHAIN + 13);
    @(negedge clk);
    chk(inject_mask == ip, "R4 foreign chain write", inject_mask, ip);

    // R9 length mismatch
    v = '0; v[21:0] = {MY_ID, 5'd2, 3'b001, 9'h1AB};
    send(v, 22);
    @(negedge clk);
    chk(dac_bus == exp_dac(), "R9 long bias write", CHAIN'(dac_bus), CHAIN'(exp_dac()));
    v = '0; v[13:0] = {MY_ID, 5'd0, 3'b010, 1'b1};
    send(v, 14);
    expect_silent(12, "R9 long read frame");

    // R8 read above the map
    v = '0; v[12:0] = {MY_ID, 5'd20, 3'b010};
    send(v, 13);
    expect_silent(12, "R8 high address read");

    // R10 back-to-back frames, one idle edge between
    v = '0; v[20:0] = {MY_ID, 5'd3, 3'b001, 8'h3C};
    send(v, 21);
    v = '0; v[20:0] = {MY_ID, 5'd4, 3'b001, 8'hC4};
    send(v, 21);
    @(negedge clk);
    m_dac[3] = 8'h3C; m_dac[4] = 8'hC4;
    chk(dac_bus == exp_dac(), "R10 back-to-back writes", CHAIN'(dac_bus), CHAIN'(exp_dac()));

    // R1 reset again restores defaults
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NUM_DAC; i++) m_dac[i] = 8'h80;
    chk(dac_bus == exp_dac() && kill_mask == '0 && inject_mask == '0, "R1 second reset",
        CHAIN'(dac_bus), CHAIN'(exp_dac()));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule